// File: doc/BRIEF.md
# Light Sensor Measurement Sequencer

This block sets the timing of conversions for a light sensor with two channels: ambient light and infrared. A modulator produces a stream of single-bit pulses. The block counts the high cycles of that stream inside an integration window. The window is timed by a counter that runs on the clock, and its width is selectable. When the window closes, the block stores the count as an unsigned result and pulses a strobe for one cycle.

Software writes a 3-bit mode field to pick a behaviour:
- one conversion, after which the block powers itself down and the result stays readable;
- conversions back to back with no gap, each one overwriting the result;
- power-down.

The block also drives a channel-select output, which tells the analog front end whether to route the ambient or the infrared photodiode into the modulator.

Top module: `light_meas_seq`

## Requirements
- R1: After reset the block is powered down: `busy_o`=0, `ir_sel_o`=0, `done_o`=0 and `data_o`=0.
- R2: Mode codes on `mode_i` are: 1 = ambient once, 2 = infrared once, 3 = ambient continuous, 4 = infrared continuous. Codes 0, 5, 6 and 7 mean power-down. A power-down write stops all conversion activity (`busy_o`=0, `ir_sel_o`=0), and no further `done_o` pulse follows. While a mode runs, `ir_sel_o` is 1 for the infrared modes and 0 for the ambient modes.
- R3: `res_sel_i` codes 0, 1, 2 and 3 select a width n of 4, 8, 12 or 16 bits. The window is 2^n clock cycles. Take edge E0 as the edge that accepts the mode write. The pulse input is sampled at edges E1 through E(2^n), and `done_o` is high in the cycle after E(2^n).
- R4: The result is the number of sampled cycles in which `pulse_i` was 1, saturating at 2^n-1.
- R5: In a once mode, exactly one conversion runs. `busy_o` falls at the same edge that raises `done_o`. After that, `data_o` holds its value and no further strobe follows, whatever `pulse_i` does.
- R6: In a continuous mode, the next window starts at the very edge where the previous one ends. Strobes therefore come every 2^n cycles, and each strobe overwrites `data_o`.
- R7: A mode write during a conversion aborts that conversion. The aborted window gives no strobe and `data_o` keeps its value. The new mode starts a fresh window at the write edge.
- R8: `done_o` is high for exactly one cycle for each update of `data_o`. `data_o` changes only in a cycle where `done_o` is high.
- R9: `res_sel_i` is sampled only at the start of a window, which is a mode write or a continuous restart. A change while a window is open has no effect on that window's length or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | One-cycle write strobe for the mode field |
| mode_i | input | 3 | Mode code, taken when `mode_we_i` is high |
| res_sel_i | input | 2 | Resolution select (window width 4/8/12/16 bits) |
| pulse_i | input | 1 | Modulator pulse stream |
| busy_o | output | 1 | A conversion window is open |
| ir_sel_o | output | 1 | Front end routes the infrared channel |
| data_o | output | 16 | Last stored conversion result |
| done_o | output | 1 | One-cycle strobe when `data_o` is updated |

## Verification
Every result appears in the cycle after edge E(2^n), where E0 is the write edge. The bench drives each window cycle on a falling edge and counts exactly 2^n falling edges after the write. It then samples `done_o` and `data_o` on the next falling edge. It also checks that `done_o` stayed low on every earlier falling edge of the window. Continuous runs are checked at the first falling edge of the following window. That is where the earlier result shows while the new window collects its first pulse. Aborts and power-down commands are followed by idle stretches with pulses present, in which the bench checks for a missing strobe and a held result.

// File: rtl/lms_pkg.sv
package lms_pkg;
  localparam int unsigned STEP_W    = 4;
  localparam int unsigned NUM_RES   = 4;
  localparam int unsigned CNT_W     = STEP_W * NUM_RES;
  localparam int unsigned RES_SEL_W = $clog2(NUM_RES);
  localparam int unsigned MODE_W    = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF      = 3'd0,
    MODE_ALS_ONCE = 3'd1,
    MODE_IR_ONCE  = 3'd2,
    MODE_ALS_CONT = 3'd3,
    MODE_IR_CONT  = 3'd4
  } mode_e;

  typedef struct packed {
    logic run;
    logic ir;
    logic once;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] code);
    mode_dec_t d;
    d = '0;
    case (code)
      MODE_ALS_ONCE: d = '{run: 1'b1, ir: 1'b0, once: 1'b1};
      MODE_IR_ONCE:  d = '{run: 1'b1, ir: 1'b1, once: 1'b1};
      MODE_ALS_CONT: d = '{run: 1'b1, ir: 1'b0, once: 1'b0};
      MODE_IR_CONT:  d = '{run: 1'b1, ir: 1'b1, once: 1'b0};
      default:       d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/lms_mode_ctrl.sv
module lms_mode_ctrl
  import lms_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              conv_end_i,
  output logic              run_o,
  output logic              ir_o
);
  mode_dec_t dec;
  logic run_q, ir_q, once_q;

  assign dec = decode_mode(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ir_q   <= 1'b0;
      once_q <= 1'b0;
    end else if (mode_we_i) begin
      run_q  <= dec.run;
      ir_q   <= dec.ir;
      once_q <= dec.once;
    end else if (conv_end_i && once_q) begin
      run_q  <= 1'b0;
      ir_q   <= 1'b0;
    end
  end

  assign run_o = run_q;
  assign ir_o  = ir_q;

  // R2
  pd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && (mode_i == 3'd0 || mode_i > 3'd4)) |=> (!run_o && !ir_o));
  // R5
  once_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_end_i && once_q && !mode_we_i) |=> !run_o);
  // R6
  cont_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_end_i && !once_q && !mode_we_i) |=> run_o);
endmodule

// File: rtl/lms_window.sv
module lms_window #(
  parameter int unsigned STEP_W    = 4,
  parameter int unsigned NUM_RES   = 4,
  localparam int unsigned CNT_W    = STEP_W * NUM_RES,
  localparam int unsigned RES_SEL_W = $clog2(NUM_RES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 run_i,
  input  logic [RES_SEL_W-1:0] res_sel_i,
  output logic [CNT_W-1:0]     lim_o,
  output logic                 last_o
);
  logic [CNT_W-1:0]     lim_tab [NUM_RES];
  logic [CNT_W-1:0]     cnt_q;
  logic [RES_SEL_W-1:0] res_q;

  for (genvar g = 0; g < NUM_RES; g++) begin : g_lim
    assign lim_tab[g] = {CNT_W{1'b1}} >> (STEP_W * (NUM_RES - 1 - g));
  end

  // resolution captured only at window start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_q <= '0;
    else if (clr_i) res_q <= res_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign lim_o  = lim_tab[res_q];
  assign last_o = (cnt_q == lim_o);

  // R3
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= lim_o));
  // R9
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> $stable(lim_o));
endmodule

// File: rtl/lms_accum.sv
module lms_accum #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             pulse_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic [CNT_W-1:0] nxt_o
);
  logic [CNT_W-1:0] acc_q;
  logic             inc;

  assign inc   = pulse_i && (acc_q != lim_i);
  assign nxt_o = inc ? acc_q + 1'b1 : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             acc_q <= '0;
    else if (clr_i)          acc_q <= '0;
    else if (run_i && inc)   acc_q <= acc_q + 1'b1;
  end

  // R4
  acc_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (nxt_o <= lim_i));
endmodule

// File: rtl/lms_result.sv
module lms_result #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_end_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [CNT_W-1:0] data_o,
  output logic             done_o
);
  logic [CNT_W-1:0] data_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= conv_end_i;
      if (conv_end_i) data_q <= val_i;
    end
  end

  assign data_o = data_q;
  assign done_o = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(data_o));
endmodule

// File: rtl/light_meas_seq.sv
module light_meas_seq
  import lms_pkg::*;
#(
  parameter int unsigned STEP_W_P  = STEP_W,
  parameter int unsigned NUM_RES_P = NUM_RES,
  localparam int unsigned CW       = STEP_W_P * NUM_RES_P,
  localparam int unsigned RSW      = $clog2(NUM_RES_P)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [RSW-1:0]    res_sel_i,
  input  logic              pulse_i,
  output logic              busy_o,
  output logic              ir_sel_o,
  output logic [CW-1:0]     data_o,
  output logic              done_o
);
  logic          run, ir, last, conv_end, clr;
  logic [CW-1:0] lim, nxt;

  // a mode write wins over a window ending in the same cycle
  assign conv_end = run && last && !mode_we_i;
  assign clr      = mode_we_i || conv_end;

  lms_mode_ctrl u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_we_i  (mode_we_i),
    .mode_i     (mode_i),
    .conv_end_i (conv_end),
    .run_o      (run),
    .ir_o       (ir)
  );

  lms_window #(.STEP_W(STEP_W_P), .NUM_RES(NUM_RES_P)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .run_i     (run),
    .res_sel_i (res_sel_i),
    .lim_o     (lim),
    .last_o    (last)
  );

  lms_accum #(.CNT_W(CW)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .run_i   (run),
    .pulse_i (pulse_i),
    .lim_i   (lim),
    .nxt_o   (nxt)
  );

  lms_result #(.CNT_W(CW)) u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_end_i (conv_end),
    .val_i      (nxt),
    .data_o     (data_o),
    .done_o     (done_o)
  );

  assign busy_o   = run;
  assign ir_sel_o = ir;

  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> !done_o);
  // R8
  done_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: tb/light_meas_seq_test.sv
`timescale 1ns/1ps
module light_meas_seq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_we_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  res_sel_i = '0;
  logic        pulse_i = 1'b0;
  logic        busy_o, ir_sel_o, done_o;
  logic [15:0] data_o;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  light_meas_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_i(mode_i),
    .res_sel_i(res_sel_i), .pulse_i(pulse_i), .busy_o(busy_o),
    .ir_sel_o(ir_sel_o), .data_o(data_o), .done_o(done_o)
  );

  // {mode, res, pulse period (0 = none), expected result}
  localparam int unsigned VEC [9][4] = '{
    '{1, 0, 1, 15}, '{2, 0, 2, 8}, '{1, 0, 3, 6}, '{2, 1, 2, 128},
    '{1, 1, 1, 255}, '{2, 2, 64, 64}, '{1, 3, 1, 65535}, '{1, 0, 0, 0},
    '{2, 1, 5, 52}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input int m, input int r);
    @(negedge clk);
    mode_we_i = 1'b1; mode_i = 3'(m); res_sel_i = 2'(r); pulse_i = 1'b0;
  endtask

  // drives one window; optionally checks the previous result at its first cycle
  task automatic win(input int n, input int per, input bit chk_prev, input int exp_prev,
                     input bit exp_ir, input string req);
    bit bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mode_we_i = 1'b0;
      if (i == 0) begin
        if (chk_prev) check(done_o && data_o == 16'(exp_prev), req, data_o, exp_prev);
        check(busy_o && ir_sel_o == exp_ir, req, {busy_o, ir_sel_o}, {1'b1, exp_ir});
      end else if (done_o) bad = 1'b1;
      pulse_i = (per != 0) && (i % per == 0);
    end
    check(!bad, req, bad, 0);
  endtask

  task automatic finish(input int exp, input string req);
    @(negedge clk);
    pulse_i = 1'b0;
    check(done_o && data_o == 16'(exp), req, data_o, exp);
  endtask

  task automatic idle(input int n, input int exp, input string req);
    bit bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mode_we_i = 1'b0; pulse_i = 1'b1;
      if (done_o || busy_o || data_o != 16'(exp)) bad = 1'b1;
    end
    pulse_i = 1'b0;
    check(!bad, req, data_o, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!busy_o && !ir_sel_o && !done_o && data_o == 0, "R1", data_o, 0);
    rst_ni = 1'b1;

    // R3 R4 R5: once conversions over the vector table
    for (int v = 0; v < 9; v++) begin
      start(VEC[v][0], VEC[v][1]);
      win(1 << (4 * (VEC[v][1] + 1)), VEC[v][2], 1'b0, 0, VEC[v][0] == 2, "R3");
      finish(VEC[v][3], "R4");
      check(!busy_o, "R5", busy_o, 0);
    end
    // R5: result held after auto power-down
    idle(30, 52, "R5");

    // R6: back-to-back windows, data overwritten
    start(3, 0);
    win(16, 1, 1'b0, 0, 1'b0, "R6");
    win(16, 2, 1'b1, 15, 1'b0, "R6");
    finish(8, "R6");

    // R2 R7: infrared continuous aborted by power-down
    start(4, 0);
    win(10, 1, 1'b0, 0, 1'b1, "R2");
    start(0, 0);
    idle(40, 8, "R7");

    // R2: reserved code powers down
    start(2, 0);
    win(3, 1, 1'b0, 0, 1'b1, "R2");
    start(6, 0);
    @(negedge clk);
    mode_we_i = 1'b0;
    check(!busy_o && !ir_sel_o, "R2", {busy_o, ir_sel_o}, 0);
    idle(30, 8, "R2");

    // R7: abort by new mode, fresh window
    start(3, 1);
    win(100, 1, 1'b0, 0, 1'b0, "R7");
    start(1, 0);
    win(16, 4, 1'b0, 0, 1'b0, "R7");
    check(data_o == 8, "R7", data_o, 8);
    finish(4, "R7");

    // R9: resolution change inside a window ignored
    start(1, 0);
    @(posedge clk);
    #1 res_sel_i = 2'd3;
    win(16, 1, 1'b0, 0, 1'b0, "R9");
    finish(15, "R9");
    // R8
    @(negedge clk);
    check(!done_o && data_o == 15, "R8", done_o, 0);
    res_sel_i = 2'd0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule